// File: doc/BRIEF.md
# Floating-Point Arithmetic Decode and Control/Status Update

This block sits at the issue stage of a single-precision floating-point pipe. It looks at a 32-bit instruction word and decides whether the word is a floating-point arithmetic operation. If it is, the block names the operation (add, subtract, multiply, divide or square root) and passes on the destination and source register indices. It also works out the rounding mode that the arithmetic unit should use. The block does no arithmetic itself.

The block holds an 8-bit floating-point control/status register. The low five bits are the exception flags. The three bits above them are the default rounding mode. An instruction whose rounding field is 7 asks for that default. Once a legal operation has been issued, the external arithmetic unit returns its five exception flags with a strobe. Those flags replace the flag field of the register; they are not OR-ed into it. Software may load the whole register through a write port, and that write takes priority over a flag update in the same cycle.

The reset input is asynchronous and active-low. Its release reaches the registers through a two-stage synchroniser. The decode outputs are combinational from the instruction word and the current register value.

Top module: `fpop_decode_csr`

## Requirements
- R1: When `insn_valid` is low, or bits 6:0 of the word differ from 1010011, `op_valid` and `illegal` are both 0 and `op_code` is 0.
- R2: Bits 31:25 select the operation, and `op_code` reports it as follows: 0000000 gives 1 (add), 0000100 gives 2 (subtract), 0001000 gives 3 (multiply), 0001100 gives 4 (divide), 0101100 gives 5 (square root). `op_code` is 0 whenever `op_valid` is low.
- R3: `rd_idx` is bits 11:7 of the word, `rs1_idx` is bits 19:15, and `rs2_idx` is bits 24:20, at all times.
- R4: `rm_eff` equals the rounding field in bits 14:12 when that field is below 7. When the field is 7, `rm_eff` equals bits 7:5 of the control/status register.
- R5: For a valid floating-point word, a resolved rounding mode above 4 (5, 6 or 7) raises `illegal`.
- R6: For a valid floating-point word, `illegal` is raised by a value in bits 31:25 that is not in the R2 list, or by square root with a nonzero bits 24:20. `illegal` and `op_valid` are never high together.
- R7: When `flags_valid` is high while a legal operation is pending and there is no software write, the register's bits 4:0 on the next cycle equal `flags_in`, and bits 7:5 keep their value.
- R8: A legal operation (`op_valid` high) makes an update pending, and a `flags_valid` strobe consumes it. A `flags_valid` strobe with nothing pending, and any illegal word, leave the register unchanged.
- R9: `csr_wr` loads `csr_wdata` into the whole register on the next cycle. It wins over a flag update in the same cycle, and that strobe still consumes the pending update.
- R10: After reset the register reads 0 and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| insn_valid | input | 1 | Instruction word is present this cycle |
| insn | input | 32 | Instruction word |
| flags_valid | input | 1 | Exception flags from the arithmetic unit are valid |
| flags_in | input | 5 | Exception flags of the completed operation |
| csr_wr | input | 1 | Software write strobe for the control/status register |
| csr_wdata | input | 8 | Software write data |
| op_valid | output | 1 | Legal floating-point arithmetic operation decoded |
| op_code | output | 3 | Operation code (0 none, 1 add, 2 sub, 3 mul, 4 div, 5 sqrt) |
| rd_idx | output | 5 | Destination register index |
| rs1_idx | output | 5 | First source register index |
| rs2_idx | output | 5 | Second source register index |
| rm_eff | output | 3 | Resolved rounding mode |
| illegal | output | 1 | Floating-point word that cannot be executed |
| csr_value | output | 8 | Current control/status register value |

## Verification
The decode sweep covers every one of the 128 operation-select values, each with all eight rounding fields and with both a zero and a nonzero second-source field. The sweep is repeated under four default rounding modes: two legal, one reserved and the dynamic code itself. This separates static from dynamic resolution and the square-root field rule from the unknown-operation rule. A second sweep walks every other major opcode, and a further check drops the valid strobe, to confirm that no stray illegal is reported. The register sequences then tell overwrite apart from accumulation: flags 10101 followed by 01010 must read back 01010 and not 11111. They also cover flags with nothing pending, flags after an illegal word, issue and flags in the same cycle, and a software write colliding with a flag update.

// File: rtl/fpdec_pkg.sv
`timescale 1ns/1ps
package fpdec_pkg;
  localparam int unsigned INSN_W  = 32;
  localparam int unsigned OPC_W   = 7;
  localparam int unsigned F7_W    = 7;
  localparam int unsigned IDX_W   = 5;
  localparam int unsigned RM_W    = 3;
  localparam int unsigned FLAG_W  = 5;
  localparam int unsigned CSR_W   = FLAG_W + RM_W;
  localparam int unsigned OP_W    = 3;
  localparam int unsigned NUM_OPS = 5;

  localparam logic [OPC_W-1:0] OPC_FP_ARITH = 7'b1010011;
  localparam logic [RM_W-1:0]  RM_DYNAMIC   = 3'd7;
  localparam logic [RM_W-1:0]  RM_MAX_OK    = 3'd4;

  typedef enum logic [OP_W-1:0] {
    FOP_NONE = 3'd0,
    FOP_ADD  = 3'd1,
    FOP_SUB  = 3'd2,
    FOP_MUL  = 3'd3,
    FOP_DIV  = 3'd4,
    FOP_SQRT = 3'd5
  } fop_e;

  // entry i decodes to operation code i+1
  localparam logic [F7_W-1:0] F7_TAB [NUM_OPS] = '{
    7'b0000000, 7'b0000100, 7'b0001000, 7'b0001100, 7'b0101100
  };

  typedef struct packed {
    logic [F7_W-1:0]  funct7;
    logic [IDX_W-1:0] rs2;
    logic [IDX_W-1:0] rs1;
    logic [RM_W-1:0]  rm;
    logic [IDX_W-1:0] rd;
    logic [OPC_W-1:0] opc;
  } insn_fields_t;
endpackage

// File: rtl/fpdec_opsel.sv
`timescale 1ns/1ps
module fpdec_opsel
  import fpdec_pkg::*;
(
  input  insn_fields_t fld,
  output fop_e         op,
  output logic         is_fp,
  output logic         shape_bad
);
  logic known;

  always_comb begin
    op    = FOP_NONE;
    known = 1'b0;
    for (int i = 0; i < NUM_OPS; i++) begin
      if (fld.funct7 == F7_TAB[i]) begin
        op    = fop_e'(OP_W'(i + 1));
        known = 1'b1;
      end
    end
  end

  assign is_fp     = (fld.opc == OPC_FP_ARITH);
  assign shape_bad = !known || ((op == FOP_SQRT) && (fld.rs2 != '0));
endmodule

// File: rtl/fpdec_rm.sv
`timescale 1ns/1ps
module fpdec_rm
  import fpdec_pkg::*;
(
  input  logic [RM_W-1:0] rm_field,
  input  logic [RM_W-1:0] frm,
  output logic [RM_W-1:0] rm_eff,
  output logic            rm_bad
);
  always_comb begin
    if (rm_field == RM_DYNAMIC) rm_eff = frm;
    else                        rm_eff = rm_field;
  end

  assign rm_bad = (rm_eff > RM_MAX_OK);
endmodule

// File: rtl/fpdec_csr.sv
`timescale 1ns/1ps
module fpdec_csr
  import fpdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              flags_valid,
  input  logic [FLAG_W-1:0] flags,
  input  logic              sw_wr,
  input  logic [CSR_W-1:0]  sw_wdata,
  output logic [CSR_W-1:0]  csr_q
);
  logic [CSR_W-1:0] csr_d;
  logic             csr_en;
  logic             pend_q;
  logic             pend_d;
  logic             pend_en;

  always_comb begin
    csr_d  = csr_q;
    csr_en = 1'b0;
    if (sw_wr) begin
      csr_d  = sw_wdata;
      csr_en = 1'b1;
    end else if (flags_valid && pend_q) begin
      csr_d  = {csr_q[CSR_W-1:FLAG_W], flags};
      csr_en = 1'b1;
    end
  end

  always_comb begin
    pend_en = issue || flags_valid;
    pend_d  = issue || (pend_q && !flags_valid);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (csr_en)  csr_q  <= csr_d;
      if (pend_en) pend_q <= pend_d;
    end
  end

  // R7
  flag_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_valid && pend_q && !sw_wr) |=>
      (csr_q[FLAG_W-1:0] == $past(flags)) &&
      (csr_q[CSR_W-1:FLAG_W] == $past(csr_q[CSR_W-1:FLAG_W])));

  // R9
  sw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr |=> (csr_q == $past(sw_wdata)));

  // R8
  no_spurious_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wr && !(flags_valid && pend_q)) |=> $stable(csr_q));

  // R8
  pend_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_valid && !issue) |=> !pend_q);
endmodule

// File: rtl/fpop_decode_csr.sv
`timescale 1ns/1ps
module fpop_decode_csr
  import fpdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_valid,
  input  logic [INSN_W-1:0] insn,
  input  logic              flags_valid,
  input  logic [FLAG_W-1:0] flags_in,
  input  logic              csr_wr,
  input  logic [CSR_W-1:0]  csr_wdata,
  output logic              op_valid,
  output logic [OP_W-1:0]   op_code,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [IDX_W-1:0]  rs1_idx,
  output logic [IDX_W-1:0]  rs2_idx,
  output logic [RM_W-1:0]   rm_eff,
  output logic              illegal,
  output logic [CSR_W-1:0]  csr_value
);
  logic         rst_meta_q;
  logic         rst_sync_n;
  insn_fields_t fld;
  fop_e         dec_op;
  logic         is_fp;
  logic         shape_bad;
  logic         rm_bad;
  logic         fp_seen;
  logic [CSR_W-1:0] csr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  assign fld = insn_fields_t'(insn);

  fpdec_opsel u_opsel (
    .fld       (fld),
    .op        (dec_op),
    .is_fp     (is_fp),
    .shape_bad (shape_bad)
  );

  fpdec_rm u_rm (
    .rm_field (fld.rm),
    .frm      (csr_q[CSR_W-1:FLAG_W]),
    .rm_eff   (rm_eff),
    .rm_bad   (rm_bad)
  );

  fpdec_csr u_csr (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .issue       (op_valid),
    .flags_valid (flags_valid),
    .flags       (flags_in),
    .sw_wr       (csr_wr),
    .sw_wdata    (csr_wdata),
    .csr_q       (csr_q)
  );

  always_comb begin
    fp_seen  = insn_valid && is_fp;
    illegal  = fp_seen && (shape_bad || rm_bad);
    op_valid = fp_seen && !shape_bad && !rm_bad;
    op_code  = op_valid ? dec_op : FOP_NONE;
  end

  assign rd_idx    = fld.rd;
  assign rs1_idx   = fld.rs1;
  assign rs2_idx   = fld.rs2;
  assign csr_value = csr_q;

  // R6
  excl_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(op_valid && illegal));

  // R1
  non_fp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!insn_valid || (insn[6:0] != OPC_FP_ARITH)) |-> (!op_valid && !illegal && (op_code == '0)));

  // R4
  rm_static_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (insn[14:12] != RM_DYNAMIC) |-> (rm_eff == insn[14:12]));

  // R4
  rm_dynamic_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (insn[14:12] == RM_DYNAMIC) |-> (rm_eff == csr_value[CSR_W-1:FLAG_W]));

  // R5
  rm_reserved_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid) |-> (rm_eff <= RM_MAX_OK));
endmodule

// File: tb/test_fpop_decode_csr.sv
`timescale 1ns/1ps
module test_fpop_decode_csr;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        insn_valid;
  logic [31:0] insn;
  logic        flags_valid;
  logic [4:0]  flags_in;
  logic        csr_wr;
  logic [7:0]  csr_wdata;
  logic        op_valid;
  logic [2:0]  op_code;
  logic [4:0]  rd_idx, rs1_idx, rs2_idx;
  logic [2:0]  rm_eff;
  logic        illegal;
  logic [7:0]  csr_value;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  fpop_decode_csr i_fpop_decode_csr (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
    .flags_valid(flags_valid), .flags_in(flags_in), .csr_wr(csr_wr),
    .csr_wdata(csr_wdata), .op_valid(op_valid), .op_code(op_code),
    .rd_idx(rd_idx), .rs1_idx(rs1_idx), .rs2_idx(rs2_idx), .rm_eff(rm_eff),
    .illegal(illegal), .csr_value(csr_value)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h insn=%08h", req, act, exp, insn);
    end
  endtask

  // returns {op_valid, illegal, op_code[2:0], rm_eff[2:0]}
  function automatic logic [7:0] model(input logic v, input logic [31:0] w, input logic [2:0] frm);
    logic [2:0] op, rme;
    logic known, bad, ok;
    case (w[31:25])
      7'b0000000: op = 3'd1;
      7'b0000100: op = 3'd2;
      7'b0001000: op = 3'd3;
      7'b0001100: op = 3'd4;
      7'b0101100: op = 3'd5;
      default:    op = 3'd0;
    endcase
    known = (op != 3'd0);
    rme   = (w[14:12] == 3'd7) ? frm : w[14:12];
    bad   = !known || (op == 3'd5 && w[24:20] != 5'd0) || (rme > 3'd4);
    if (!v || w[6:0] != 7'b1010011) return {2'b00, 3'd0, rme};
    ok = !bad;
    return {ok, bad, ok ? op : 3'd0, rme};
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; insn_valid = 1'b0; insn = '0; flags_valid = 1'b0;
    flags_in = '0; csr_wr = 1'b0; csr_wdata = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
  endtask

  task automatic sw_write(input logic [7:0] d);
    csr_wr = 1'b1; csr_wdata = d;
    step();
    csr_wr = 1'b0;
  endtask

  task automatic issue(input logic [31:0] w);
    insn = w; insn_valid = 1'b1;
    step();
    insn_valid = 1'b0;
  endtask

  task automatic flags(input logic [4:0] f);
    flags_valid = 1'b1; flags_in = f;
    step();
    flags_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] e;
    logic [2:0] frm_set [4] = '{3'd0, 3'd3, 3'd5, 3'd7};
    logic [31:0] legal_add;
    legal_add = {7'b0000000, 5'd2, 5'd1, 3'd0, 5'd3, 7'b1010011};

    do_reset();
    // R10
    chk("R10 csr after reset", csr_value, 8'h00);
    chk("R10 op_valid after reset", op_valid, 0);

    for (int k = 0; k < 4; k++) begin
      sw_write({frm_set[k], 5'b10110});
      chk("R9 sw write", csr_value, {frm_set[k], 5'b10110});
      for (int f7 = 0; f7 < 128; f7++)
        for (int rm = 0; rm < 8; rm++)
          for (int s = 0; s < 2; s++) begin
            logic [4:0] r2, r1, rd;
            r2 = s ? 5'd9 : 5'd0;
            r1 = ~f7[4:0];
            rd = f7[4:0] ^ 5'(rm);
            insn = {f7[6:0], r2, r1, rm[2:0], rd, 7'b1010011};
            insn_valid = 1'b1;
            #1;
            e = model(1'b1, insn, frm_set[k]);
            chk("R2 op_code", op_code, e[5:3]);
            chk("R4 rm_eff", rm_eff, e[2:0]);
            chk((e[2:0] > 3'd4) ? "R5 illegal" : "R6 illegal", illegal, e[6]);
            chk("R6 op_valid", op_valid, e[7]);
            chk("R3 fields", {rd_idx, rs1_idx, rs2_idx}, {rd, r1, r2});
            @(negedge clk);
          end
      insn_valid = 1'b0;
      // R8 no flag strobe, register untouched
      chk("R8 csr held during sweep", csr_value, {frm_set[k], 5'b10110});
    end

    for (int opc = 0; opc < 128; opc++) begin
      if (opc == 7'b1010011) continue;
      insn = {7'b0000000, 5'd1, 5'd1, 3'd0, 5'd1, opc[6:0]};
      insn_valid = 1'b1;
      #1;
      chk("R1 other opcode", {op_valid, illegal, op_code}, 5'd0);
      @(negedge clk);
    end
    insn = {7'b0000010, 5'd0, 5'd0, 3'd5, 5'd0, 7'b1010011};
    insn_valid = 1'b0;
    #1;
    chk("R1 valid low", {op_valid, illegal, op_code}, 5'd0);
    @(negedge clk);

    do_reset();
    flags(5'h1F);
    chk("R8 flags with nothing pending", csr_value, 8'h00);
    issue({7'b0000010, 5'd0, 5'd0, 3'd0, 5'd0, 7'b1010011});
    flags(5'h1F);
    chk("R8 flags after illegal word", csr_value, 8'h00);
    sw_write(8'h40);
    issue(legal_add);
    flags(5'h15);
    chk("R7 first flag update", csr_value, 8'h55);
    flags(5'h0A);
    chk("R8 second strobe without issue", csr_value, 8'h55);
    issue(legal_add);
    flags(5'h0A);
    chk("R7 overwrite not accumulate", csr_value, 8'h4A);
    issue(legal_add);
    csr_wr = 1'b1; csr_wdata = 8'h83;
    flags(5'h1F);
    csr_wr = 1'b0;
    chk("R9 write beats flags", csr_value, 8'h83);
    flags(5'h01);
    chk("R9 collided strobe consumed pending", csr_value, 8'h83);
    insn = legal_add; insn_valid = 1'b1;
    flags(5'h11);
    insn_valid = 1'b0;
    chk("R8 same-cycle issue and flags", csr_value, 8'h83);
    flags(5'h04);
    chk("R7 update after same-cycle issue", csr_value, 8'h84);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule